// File: doc/BRIEF.md
# Step Attenuator Control Latch with Power-Up Preset

This block is the digital control core that sits on the device side of a six-bit step attenuator. It takes six active-low control lines, a latch enable, two preset select inputs and a synchronous power-on reset, and it holds the six-bit attenuation code that drives the switching stages. In each code bit i, a low level inserts 2^i × 0.5 dB, so code 6'b111111 is 0 dB and 6'b000000 is the full 31.5 dB.

After reset the block waits a settling delay, given as a clock-cycle count parameter, and then loads a first state. The latch-enable level at that moment picks the source. When it is high, the control lines give the state. When it is low, a fixed four-entry preset table indexed by the two select inputs gives the state. From then on the held code follows the control lines on every clock while latch enable is high, and it stays frozen while latch enable is low. A short high pulse on latch enable therefore captures the lines present at that edge. A ready output marks that the initial load has taken place.

Top module: `atten_ctrl_core`

## Requirements
- R1: While reset is high, and on every cycle before the initial load, `att_code` is 6'b000000 (full attenuation) and `ready` is low.
- R2: The initial load happens on the PWRUP_CYCLES-th rising clock edge after reset is released. `ready` rises on that same edge and stays high until reset is asserted again.
- R3: If `latch_en` is high at the load edge, `att_code` takes the value of `ctl_n` and `pup_sel` has no effect.
- R4: If `latch_en` is low at the load edge, `att_code` takes the preset chosen by `pup_sel`: 2'b00 gives 6'b000000 (31.5 dB), 2'b01 gives 6'b001111 (24 dB), 2'b10 gives 6'b011111 (16 dB) and 2'b11 gives 6'b111111 (0 dB).
- R5: After ready, `att_code` equals the `ctl_n` value sampled at every rising edge where `latch_en` is high.
- R6: After ready, `att_code` does not change on any edge where `latch_en` is low, whatever `ctl_n` and `pup_sel` do.
- R7: A one-cycle high pulse on `latch_en` captures the `ctl_n` value present at that edge, and the code then keeps that value after `ctl_n` changes.
- R8: Before the initial load, activity on `ctl_n` and `latch_en` leaves `att_code` at full attenuation.
- R9: Asserting reset after ready returns `att_code` to 6'b000000 and `ready` to low, and it restarts the full settling delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ctl_n | input | 6 | Active-low attenuation control lines |
| latch_en | input | 1 | High: code follows lines; low: code held |
| pup_sel | input | 2 | Preset table index used at power-up when latch_en is low |
| att_code | output | 6 | Held active-low attenuation code |
| ready | output | 1 | High once the initial load has completed |

## Verification
The in-line properties watch every cycle. They check that the code stays at full attenuation until ready, that it is stable on edges with latch enable low, that it tracks the sampled lines on edges with latch enable high, that ready never falls outside reset, and that the initial load lands on the last count of the delay and takes the source that the latch-enable level selects. The directed scenarios are the only place where the exact values of each preset entry, the precise edge of the load counted from reset release, the capture of a single latch pulse, and the restart after a second reset become visible.

// File: rtl/atten_pkg.sv
package atten_pkg;

    localparam int CODE_W = 6;
    localparam int SEL_W  = 2;

    typedef logic [CODE_W-1:0] att_code_t;

    // all bits low inserts every stage
    localparam att_code_t CODE_FULL  = '0;
    localparam att_code_t CODE_CLEAR = '1;

    typedef enum logic [SEL_W-1:0] {
        PRE_MAX  = 2'b00,
        PRE_24DB = 2'b01,
        PRE_16DB = 2'b10,
        PRE_NONE = 2'b11
    } preset_e;

    // attenuation in half-dB units for each preset entry
    function automatic int unsigned preset_halfdb(preset_e sel);
        case (sel)
            PRE_MAX:  return 63;
            PRE_24DB: return 48;
            PRE_16DB: return 32;
            default:  return 0;
        endcase
    endfunction

    // active-low code: a low bit i adds 2^i half-dB
    function automatic att_code_t halfdb_to_code(int unsigned halfdb);
        att_code_t raw;
        raw = att_code_t'(halfdb);
        return ~raw;
    endfunction

    function automatic att_code_t preset_code(preset_e sel);
        return halfdb_to_code(preset_halfdb(sel));
    endfunction

endpackage

// File: rtl/atten_pwrup_timer.sv
module atten_pwrup_timer #(
    parameter int unsigned PWRUP_CYCLES = 40_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic load_now,
    output logic ready
);
    localparam int unsigned CNT_W = (PWRUP_CYCLES > 1) ? $clog2(PWRUP_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PWRUP_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    assign load_now = !done_q && (cnt_q == LAST);
    assign ready    = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            if (cnt_q == LAST) begin
                done_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assert_ready_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        $past(done_q) |-> done_q);

    assert_load_on_last_count_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(cnt_q) == LAST);

    assert_load_sets_ready_R2: assert property (@(posedge clk) disable iff (rst)
        load_now |=> done_q);

endmodule

// File: rtl/atten_preset_sel.sv
module atten_preset_sel
    import atten_pkg::*;
(
    input  logic [SEL_W-1:0] pup_sel,
    output att_code_t        preset
);
    always_comb begin
        preset = preset_code(preset_e'(pup_sel));
    end
endmodule

// File: rtl/atten_state_reg.sv
module atten_state_reg
    import atten_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load_now,
    input  logic      ready,
    input  logic      latch_en,
    input  att_code_t ctl_n,
    input  att_code_t preset,
    output att_code_t state
);
    att_code_t state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CODE_FULL;
        end else if (load_now) begin
            state_q <= latch_en ? ctl_n : preset;
        end else if (ready && latch_en) begin
            state_q <= ctl_n;
        end
    end

    assign state = state_q;

    assert_full_until_ready_R1: assert property (@(posedge clk) disable iff (rst)
        !ready |-> state_q == CODE_FULL);

    assert_hold_when_closed_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(ready) && !$past(latch_en)) |-> $stable(state_q));

    assert_follow_when_open_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(ready) && $past(latch_en)) |-> state_q == $past(ctl_n));

    assert_load_from_lines_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(load_now) && $past(latch_en)) |-> state_q == $past(ctl_n));

    assert_load_from_preset_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(load_now) && !$past(latch_en)) |-> state_q == $past(preset));

endmodule

// File: rtl/atten_ctrl_core.sv
module atten_ctrl_core
    import atten_pkg::*;
#(
    parameter int unsigned PWRUP_CYCLES = 40_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] ctl_n,
    input  logic              latch_en,
    input  logic [SEL_W-1:0]  pup_sel,
    output logic [CODE_W-1:0] att_code,
    output logic              ready
);
    logic      load_now;
    att_code_t preset;
    att_code_t state;

    atten_pwrup_timer #(
        .PWRUP_CYCLES(PWRUP_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load_now (load_now),
        .ready    (ready)
    );

    atten_preset_sel u_preset (
        .pup_sel (pup_sel),
        .preset  (preset)
    );

    atten_state_reg u_state (
        .clk      (clk),
        .rst      (rst),
        .load_now (load_now),
        .ready    (ready),
        .latch_en (latch_en),
        .ctl_n    (ctl_n),
        .preset   (preset),
        .state    (state)
    );

    assign att_code = state;

    assert_reset_clears_R9: assert property (@(posedge clk)
        $past(rst) |-> (att_code == CODE_FULL && !ready));

endmodule

// File: tb/atten_ctrl_core_tb.sv
module atten_ctrl_core_tb;
    localparam int unsigned LIMIT = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] ctl_n = 6'h3F;
    logic       latch_en = 1'b0;
    logic [1:0] pup_sel = 2'b00;
    logic [5:0] att_code;
    logic       ready;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    atten_ctrl_core #(.PWRUP_CYCLES(LIMIT)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .ctl_n    (ctl_n),
        .latch_en (latch_en),
        .pup_sel  (pup_sel),
        .att_code (att_code),
        .ready    (ready)
    );

    task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // reset, then run the settling delay with activity on the lines
    task automatic t_powerup(input logic le_v, input logic [1:0] sel_v,
                             input logic [5:0] data_v, input logic [5:0] exp_v,
                             input string req);
        @(negedge clk);
        rst = 1'b1;
        latch_en = le_v;
        pup_sel = sel_v;
        @(negedge clk);
        @(negedge clk);
        chk("R1 reset code", att_code, 6'b000000);
        chk("R9 reset ready", {5'b0, ready}, 6'd0);
        rst = 1'b0;
        for (int k = 1; k < LIMIT; k++) begin
            @(negedge clk);
            chk("R8 code before load", att_code, 6'b000000);
            chk("R2 ready before load", {5'b0, ready}, 6'd0);
            ctl_n = (k == LIMIT - 1) ? data_v : 6'(k * 7 + 5);
            if (k != LIMIT - 1 && le_v) pup_sel = 2'(k);
        end
        pup_sel = sel_v;
        if (le_v) pup_sel = ~sel_v;
        @(negedge clk);
        chk("R2 ready at load edge", {5'b0, ready}, 6'd1);
        chk(req, att_code, exp_v);
        @(negedge clk);
        chk("R2 ready stays", {5'b0, ready}, 6'd1);
    endtask

    task automatic t_follow();
        latch_en = 1'b1;
        for (int k = 0; k < 4; k++) begin
            ctl_n = 6'(k * 13 + 9);
            @(negedge clk);
            chk("R5 follows lines", att_code, 6'(k * 13 + 9));
        end
    endtask

    task automatic t_hold();
        logic [5:0] held;
        latch_en = 1'b1;
        ctl_n = 6'b100110;
        @(negedge clk);
        held = 6'b100110;
        latch_en = 1'b0;
        for (int k = 0; k < 5; k++) begin
            ctl_n = 6'(k * 11 + 1);
            pup_sel = 2'(k);
            @(negedge clk);
            chk("R6 holds while closed", att_code, held);
        end
    endtask

    task automatic t_pulse();
        latch_en = 1'b0;
        ctl_n = 6'b010101;
        @(negedge clk);
        latch_en = 1'b1;
        ctl_n = 6'b110011;
        @(negedge clk);
        latch_en = 1'b0;
        ctl_n = 6'b001100;
        chk("R7 pulse captures", att_code, 6'b110011);
        @(negedge clk);
        @(negedge clk);
        chk("R7 pulse value held", att_code, 6'b110011);
    endtask

    initial begin
        t_powerup(1'b0, 2'b00, 6'b101010, 6'b000000, "R4 preset 00");
        t_powerup(1'b0, 2'b01, 6'b101010, 6'b001111, "R4 preset 01");
        t_powerup(1'b0, 2'b10, 6'b101010, 6'b011111, "R4 preset 10");
        t_powerup(1'b0, 2'b11, 6'b000001, 6'b111111, "R4 preset 11");
        // previous state was 0 dB: reset must bring it back to full (R9)
        t_powerup(1'b1, 2'b01, 6'b101010, 6'b101010, "R3 lines at load");
        t_powerup(1'b1, 2'b00, 6'b111111, 6'b111111, "R3 lines ignore preset");
        t_follow();
        t_hold();
        t_pulse();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule